// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus that a target has left busy, typically by holding SDA low in the middle of a byte after the controller lost its place. When recovery is requested, the block holds the main bus controller in reset, lets go of both lines, and reads them back through a synchronizer. If both lines already read high, it finishes at once. If not, it makes attempts: each attempt drives SCL low for a fixed number of clock cycles and then releases it, so the target can shift out whatever bit it was stuck on. After each release it waits until SCL really reads high, which allows for a target that stretches the clock. If SCL never comes back, it waits for a bounded settle time instead. It then samples the bus again.

The sequence ends when both lines read high, or when the attempt limit is reached. In both cases the block emits a one-cycle completion pulse and a one-cycle reinitialise strobe for the controller, which clears its status flags, clears its transfer count and flushes its data buffer. It also releases the controller reset and holds a success or failure verdict until the next request. The block never drives SDA, never forms a STOP condition and does not look at data.

States: IDLE (waits for a request), RELEASE (lines released, waits for the synchronizer to settle), CHECK (samples the bus), PULSE_LOW (drives SCL low), WAIT_HIGH (SCL released, waits for it to read high or for the settle timeout), DONE (completion cycle). Transitions: IDLE to RELEASE on start; RELEASE to CHECK when the settle timer expires; CHECK to DONE when the bus is free or the limit is reached, otherwise CHECK to PULSE_LOW; PULSE_LOW to WAIT_HIGH after the pulse width; WAIT_HIGH to CHECK when SCL reads high or the timeout expires; DONE to IDLE.

Top module: `i2c_unjam`

## Requirements
- R1: After reset every output is low, and stays low until a request arrives.
- R2: ctrl_rst is high in every cycle from the cycle after the accepted start up to, but not including, the done cycle, and it is low in the done cycle and afterwards.
- R3: sda_drive_low is never asserted, and SCL is not driven before the first bus sample.
- R4: If both lines read high at the first sample, no SCL pulse is generated and the recovery ends with ok=1, fail=0.
- R5: Every SCL pulse keeps scl_drive_low high for exactly PULSE_CYC consecutive cycles.
- R6: After an SCL release, no new pulse starts until SCL has read high (when that happens within SETTLE_CYC cycles).
- R7: If the target frees the bus after N pulses, with N no larger than MAX_TRIES, exactly N pulses are made and the verdict is ok=1, fail=0.
- R8: If the bus never frees, exactly MAX_TRIES pulses are made and the verdict is ok=0, fail=1.
- R9: If SCL is stuck low, each attempt ends after the settle timeout, and the recovery still terminates with MAX_TRIES pulses and fail=1.
- R10: done and ctrl_reinit are high together for exactly one cycle per recovery, and in that cycle exactly one of ok and fail is set. The verdict holds until the next accepted start.
- R11: A start pulse while a recovery is running is ignored. It changes neither the pulse count nor the verdict, and it does not begin a second recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Recovery request, accepted in IDLE |
| scl_in | input | 1 | SCL line level as read from the pad |
| sda_in | input | 1 | SDA line level as read from the pad |
| scl_drive_low | output | 1 | Pulls SCL low when high |
| sda_drive_low | output | 1 | Pulls SDA low when high (never asserted) |
| ctrl_rst | output | 1 | Holds the main controller in reset during recovery |
| ctrl_reinit | output | 1 | One-cycle strobe: clear controller status, count and data buffer |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Bus read free at the end of the last recovery |
| fail | output | 1 | Attempt limit reached without a free bus |

## Verification
The bench models a target that holds SDA low until it has seen a chosen number of SCL pulses. It can stretch each SCL release by a few cycles or hold SCL low forever. The key cases are zero pulses, exactly the limit, and one past the limit. An off-by-one in the attempt counter gives one pulse too many or too few, or a failure verdict on the last allowed attempt. A design that samples too early after release pulses again while the target still stretches SCL. One that mishandles a stuck clock either hangs or stops short of the limit. A mid-run start that restarts the sequence shows up as an extra pulse or as ctrl_rst reasserting after done.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_CHECK,
        ST_PULSE_LOW,
        ST_WAIT_HIGH,
        ST_DONE
    } unjam_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/unjam_sync.sv
// Multi-stage synchronizer for the line inputs; reset value is the idle level.
// STAGES must be at least 2.
module unjam_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] shreg;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shreg <= '1;
            else        shreg <= {shreg[STAGES-2:0], d[b]};
        end
        assign q[b] = shreg[STAGES-1];
    end

endmodule

// File: rtl/unjam_timer.sv
// Loadable down-counter; expired while the count is zero.
module unjam_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/unjam_attempts.sv
// Counts SCL pulse attempts of one recovery.
module unjam_attempts #(
    parameter int LIMIT = 100,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    output logic [CW-1:0] count,
    output logic          at_limit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (bump)  count <= count + 1'b1;
    end

    assign at_limit = (count == CW'(LIMIT));

    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(LIMIT)); // R8

endmodule

// File: rtl/i2c_unjam.sv
module i2c_unjam #(
    parameter int PULSE_CYC   = 1000,
    parameter int SETTLE_CYC  = 2000,
    parameter int MAX_TRIES   = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic ctrl_rst,
    output logic ctrl_reinit,
    output logic done,
    output logic ok,
    output logic fail
);
    import i2c_unjam_pkg::*;

    localparam int TMAX = max3(PULSE_CYC, SETTLE_CYC, SYNC_STAGES + 1);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int CW   = $clog2(MAX_TRIES + 1);

    unjam_state_e state_q, state_d;

    logic          scl_s, sda_s, bus_free;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          try_clear, try_bump, at_limit;
    logic [CW-1:0] try_count;
    logic          set_ok, set_fail;
    logic [TW-1:0] low_run;

    unjam_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    assign bus_free = scl_s & sda_s;

    unjam_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    unjam_attempts #(.LIMIT(MAX_TRIES)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (try_clear),
        .bump     (try_bump),
        .count    (try_count),
        .at_limit (at_limit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        try_clear = 1'b0;
        try_bump  = 1'b0;
        set_ok    = 1'b0;
        set_fail  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_RELEASE;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(SYNC_STAGES);
                    try_clear = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (tmr_exp) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (bus_free) begin
                    state_d = ST_DONE;
                    set_ok  = 1'b1;
                end else if (at_limit) begin
                    state_d  = ST_DONE;
                    set_fail = 1'b1;
                end else begin
                    state_d  = ST_PULSE_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                    try_bump = 1'b1;
                end
            end
            ST_PULSE_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_WAIT_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_CYC - 1);
                end
            end
            ST_WAIT_HIGH: begin
                if (scl_s || tmr_exp) state_d = ST_CHECK;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Verdict flags, held until the next accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok   <= 1'b0;
            fail <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            ok   <= 1'b0;
            fail <= 1'b0;
        end else begin
            if (set_ok)   ok   <= 1'b1;
            if (set_fail) fail <= 1'b1;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        ctrl_rst      = 1'b0;
        ctrl_reinit   = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_RELEASE:   ctrl_rst = 1'b1;
            ST_CHECK:     ctrl_rst = 1'b1;
            ST_PULSE_LOW: begin
                ctrl_rst      = 1'b1;
                scl_drive_low = 1'b1;
            end
            ST_WAIT_HIGH: ctrl_rst = 1'b1;
            ST_DONE: begin
                done        = 1'b1;
                ctrl_reinit = 1'b1;
            end
            default: ;
        endcase
    end

    // Length of the current low drive, for the pulse-width check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_run <= '0;
        else if (scl_drive_low) low_run <= low_run + 1'b1;
        else                    low_run <= '0;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> (low_run == TW'(PULSE_CYC))); // R5

    AST_RST_WHILE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> ctrl_rst); // R2

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_rst) && !ctrl_rst |-> done); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok ^ fail)); // R10

    AST_FREE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && bus_free) |=> !scl_drive_low); // R4

    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (try_count == CW'(MAX_TRIES))); // R8

endmodule

// File: tb/i2c_unjam_tb.sv
module i2c_unjam_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE  = 12;
    localparam int SETTLE = 40;
    localparam int TRIES  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_in, sda_in;
    logic scl_drive_low, sda_drive_low, ctrl_rst, ctrl_reinit, done, ok, fail;

    int errors = 0;
    int checks = 0;

    // Target and line model
    int n_free      = 0;
    int pulses_done = 0;
    int stretch_cnt = 0;
    bit scl_stuck   = 1'b0;

    assign scl_in = !scl_drive_low && (stretch_cnt == 0) && !scl_stuck;
    assign sda_in = !sda_drive_low && (pulses_done >= n_free);

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_unjam #(
        .PULSE_CYC  (PULSE),
        .SETTLE_CYC (SETTLE),
        .MAX_TRIES  (TRIES),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low),
        .ctrl_rst     (ctrl_rst),
        .ctrl_reinit  (ctrl_reinit),
        .done         (done),
        .ok           (ok),
        .fail         (fail)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int n, input bit stuck);
        if (stuck || n > TRIES) return TRIES;
        return n;
    endfunction

    function automatic bit exp_ok(input int n, input bit stuck);
        return !stuck && (n <= TRIES);
    endfunction

    task automatic recover(input int n, input int s, input bit stuck, input bit poke,
                           input string req);
        int  rises = 0, width = 0, cyc = 0;
        int  rst_bad = 0, reinit_bad = 0, sda_bad = 0, early = 0;
        bit  prev = 1'b0;
        int  ep;
        bit  eo;
        ep = exp_pulses(n, stuck);
        eo = exp_ok(n, stuck);
        n_free = n; scl_stuck = stuck; pulses_done = 0; stretch_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && cyc < 20000) begin
            if (!ctrl_rst)     rst_bad++;
            if (ctrl_reinit)   reinit_bad++;
            if (sda_drive_low) sda_bad++;
            if (scl_drive_low && !prev) begin
                rises++;
                if (stretch_cnt != 0) early++;
            end
            if (scl_drive_low) width++;
            if (stretch_cnt > 0) stretch_cnt--;
            if (!scl_drive_low && prev) begin
                check(width == PULSE, "R5 pulse width", width, PULSE);
                width = 0;
                pulses_done++;
                stretch_cnt = s;
            end
            prev = scl_drive_low;
            start = poke && (cyc == 30);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        check(cyc < 20000, "R10 recovery terminates", cyc, 20000);
        check(ctrl_reinit == 1'b1, "R10 reinit with done", ctrl_reinit, 1);
        check(ctrl_rst == 1'b0, "R2 reset released at done", ctrl_rst, 0);
        check(rst_bad == 0, "R2 reset held during recovery", rst_bad, 0);
        check(reinit_bad == 0, "R10 reinit only at done", reinit_bad, 0);
        check(sda_bad == 0, "R3 SDA never driven", sda_bad, 0);
        check(early == 0, "R6 no pulse while SCL stretched", early, 0);
        check(rises == ep, req, rises, ep);
        check(ok == eo, {req, " ok"}, ok, eo);
        check(fail == !eo, {req, " fail"}, fail, !eo);
        @(negedge clk);
        check(done == 1'b0, "R10 done lasts one cycle", done, 0);
        repeat (5) @(negedge clk);
        check(ok == eo && fail == !eo, "R10 verdict held", {ok, fail}, {eo, !eo});
        check(ctrl_rst == 1'b0 && scl_drive_low == 1'b0, "R11 no second recovery",
              {ctrl_rst, scl_drive_low}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1C2B));
        repeat (3) @(negedge clk);
        check({scl_drive_low, sda_drive_low, ctrl_rst, ctrl_reinit, done, ok, fail} == 7'b0,
              "R1 outputs during reset", 1, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({scl_drive_low, sda_drive_low, ctrl_rst, ctrl_reinit, done, ok, fail} == 7'b0,
              "R1 outputs idle after reset", 1, 0);

        recover(0, 0, 1'b0, 1'b0, "R4 free bus pulses");
        recover(1, 0, 1'b0, 1'b0, "R7 one pulse");
        recover(3, 8, 1'b0, 1'b0, "R6 stretched pulses");
        recover(TRIES, 0, 1'b0, 1'b0, "R7 exactly at limit");
        recover(TRIES + 1, 0, 1'b0, 1'b0, "R8 one past limit");
        recover(0, 0, 1'b1, 1'b0, "R9 stuck SCL");
        recover(5, 2, 1'b0, 1'b1, "R11 start while busy");

        for (int i = 0; i < 8; i++) begin
            int n, s;
            n = $urandom_range(0, TRIES + 5);
            s = $urandom_range(0, 10);
            recover(n, s, 1'b0, 1'b0, "R7 random target");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule